// File: doc/BRIEF.md
# Wake-Capable Interrupt Sense Controller

This block sits in the always-on domain and watches two groups of interrupt sources while the rest of the chip may be powered down. The first group is a set of peripheral interrupt lines. Each line is sensed as an active-high level and is driven onto its own output line, gated by an enable bit. The second group is a set of system-wake pins. Each wake pin has a programmable sense mode. The mode selects rising edge, falling edge, both edges, active-high level or active-low level. All wake events are merged onto one shared interrupt output.

Any enabled source that becomes active also raises a wake request toward the power sequencer. Every input is asynchronous and passes through a two-flop synchronizer. A third flop holds the previous value for edge detection. Edge events are held in sticky status bits, and software clears them by writing a 1. Level events are never held; the status shows the live, enable-qualified input.

Software uses a plain register port. A write takes effect at the clock edge when the write strobe is high. A read is combinational from the read address.

Top module: `wake_sense_ctrl`

## Requirements
- R1: Source numbering is fixed. Peripheral input i uses bit i of the enable register (address 0) and of the status register (address 1). Wake input j uses bit 8+j of both registers. All registers are 32 bits wide and unused bits read 0.
- R2: Peripheral output periph_irq[i] is 1 exactly when enable bit i is set, the peripheral mode of input i is 4, and the synchronized input is high. Every other output line is unaffected.
- R3: Peripheral modes are at address 3, input i in bits [4i+3:4i]. A written 0 reads back 0, which disables the input. Any nonzero written code reads back 4 (active-high level).
- R4: Wake modes are at address 2, wake input j in bits [4j+3:4j]. Code 1 latches a rising edge, code 2 latches a falling edge and code 3 latches either edge.
- R5: Code 4 makes a wake input active while it is high, and code 8 while it is low. Neither code latches, so the source goes inactive as soon as the input leaves its active level.
- R6: Wake code 0, and every code other than 1, 2, 3, 4 and 8, never makes the source active. Writing such a code drops any latched event.
- R7: Writing address 1 with bit 8+j set clears the latched event of wake input j. Written zeros have no effect, and bits 0..7 of that write are ignored.
- R8: wake_irq is 1 exactly when at least one wake input is active, where active means enabled and sensed.
- R9: wake_req is 1 when any peripheral output or any wake input is active.
- R10: Latency is counted from the clock edge after an input changes. A level change reaches the outputs after 2 clock edges, and an edge event is latched after 3.
- R11: After reset all registers read 0 and all outputs are 0.
- R12: An edge that occurs while the wake input's enable bit is clear is not latched, and enabling the input afterwards does not create an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_in | input | NUM_PERIPH | Asynchronous peripheral interrupt lines |
| wake_in | input | NUM_WAKE | Asynchronous system-wake pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| periph_irq | output | NUM_PERIPH | Per-peripheral interrupt outputs |
| wake_irq | output | 1 | Shared wake interrupt |
| wake_req | output | 1 | Wake request to the power sequencer |

## Verification
The assertions check several rules on every cycle:
- Stored peripheral modes are always 0 or 4.
- A latched wake event only appears after a qualifying, enabled edge.
- A clear with no new event empties the latch.
- No peripheral line or shared wake interrupt is high without a matching enable.

The correct mapping of each sense code to real edges and levels can only be shown by the bench scenarios. The same holds for exact synchronizer latency, for write-one-to-clear behaviour seen through the status register, and for the normalisation of peripheral codes. The bench sweeps every wake lane through every code and input transition to show these.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned SLOTS  = 8;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef logic [MODE_W-1:0] sense_t;

  localparam sense_t SENSE_OFF  = 4'd0;
  localparam sense_t SENSE_RISE = 4'd1;
  localparam sense_t SENSE_FALL = 4'd2;
  localparam sense_t SENSE_BOTH = 4'd3;
  localparam sense_t SENSE_HIGH = 4'd4;
  localparam sense_t SENSE_LOW  = 4'd8;

  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_WMODE = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PMODE = 2'd3;

  function automatic logic mode_is_edge(sense_t m);
    return (m == SENSE_RISE) || (m == SENSE_FALL) || (m == SENSE_BOTH);
  endfunction

  function automatic logic edge_hit(sense_t m, logic cur, logic prv);
    logic up, dn;
    up = cur & ~prv;
    dn = ~cur & prv;
    return (up && (m == SENSE_RISE || m == SENSE_BOTH)) ||
           (dn && (m == SENSE_FALL || m == SENSE_BOTH));
  endfunction

  function automatic logic level_hit(sense_t m, logic cur);
    return (m == SENSE_HIGH && cur) || (m == SENSE_LOW && !cur);
  endfunction

  function automatic sense_t periph_fix(sense_t m);
    return (m == SENSE_OFF) ? SENSE_OFF : SENSE_HIGH;
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/wk_cfg_regs.sv
module wk_cfg_regs
  import wk_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned NUM_WAKE   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [2*SLOTS-1:0]               en_o,
  output logic [NUM_WAKE-1:0][MODE_W-1:0]  wmode_o,
  output logic [NUM_PERIPH-1:0][MODE_W-1:0] pmode_o,
  output logic [NUM_WAKE-1:0]              clr_o
);
  logic [2*SLOTS-1:0]                en_q;
  logic [NUM_WAKE-1:0][MODE_W-1:0]   wmode_q;
  logic [NUM_PERIPH-1:0][MODE_W-1:0] pmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      wmode_q <= '0;
      pmode_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_EN:    en_q <= wr_data[2*SLOTS-1:0];
        ADDR_WMODE: begin
          for (int j = 0; j < NUM_WAKE; j++)
            wmode_q[j] <= wr_data[MODE_W*j +: MODE_W];
        end
        ADDR_PMODE: begin
          for (int i = 0; i < NUM_PERIPH; i++)
            pmode_q[i] <= periph_fix(wr_data[MODE_W*i +: MODE_W]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int j = 0; j < NUM_WAKE; j++)
      clr_o[j] = wr_en && (wr_addr == ADDR_STAT) && wr_data[SLOTS + j];
  end

  assign en_o    = en_q;
  assign wmode_o = wmode_q;
  assign pmode_o = pmode_q;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pchk
    // R3: stored peripheral mode is only ever off or active-high
    a_r3_pmode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode_q[i] == SENSE_OFF) || (pmode_q[i] == SENSE_HIGH));
  end
endmodule

// File: rtl/wk_wake_lane.sv
module wk_wake_lane
  import wk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cur_i,
  input  sense_t mode_i,
  input  logic   en_i,
  input  logic   clr_i,
  output logic   active_o
);
  logic prev_q;
  logic latch_q;
  logic ev;
  logic edge_mode;

  assign edge_mode = mode_is_edge(mode_i);
  assign ev        = en_i && edge_hit(mode_i, cur_i, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= cur_i;
      latch_q <= edge_mode ? ((latch_q & ~clr_i) | ev) : 1'b0;
    end
  end

  assign active_o = en_i && (edge_mode ? latch_q : level_hit(mode_i, cur_i));

  // R4: a latched event only appears after a qualifying edge
  a_r4_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(ev));
  // R12: nothing is latched while the lane is disabled
  a_r12_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(en_i));
  // R7: a clear with no new event empties the latch
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ev) |=> !latch_q);
endmodule

// File: rtl/wake_sense_ctrl.sv
module wake_sense_ctrl
  import wk_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned NUM_WAKE   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_in,
  input  logic [NUM_WAKE-1:0]   wake_in,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [1:0]            rd_addr,
  output logic [31:0]           rd_data,
  output logic [NUM_PERIPH-1:0] periph_irq,
  output logic                  wake_irq,
  output logic                  wake_req
);
  localparam int unsigned IN_W = NUM_PERIPH + NUM_WAKE;

  logic [IN_W-1:0]                   sync_all;
  logic [NUM_PERIPH-1:0]             p_sync;
  logic [NUM_WAKE-1:0]               w_sync;
  logic [2*SLOTS-1:0]                en;
  logic [NUM_WAKE-1:0][MODE_W-1:0]   wmode;
  logic [NUM_PERIPH-1:0][MODE_W-1:0] pmode;
  logic [NUM_WAKE-1:0]               w_clr;
  logic [NUM_WAKE-1:0]               w_act;
  logic [2*SLOTS-1:0]                status;

  wk_sync #(.WIDTH(IN_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({wake_in, periph_in}),
    .sync_o  (sync_all)
  );

  assign p_sync = sync_all[NUM_PERIPH-1:0];
  assign w_sync = sync_all[IN_W-1:NUM_PERIPH];

  wk_cfg_regs #(.NUM_PERIPH(NUM_PERIPH), .NUM_WAKE(NUM_WAKE)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_o    (en),
    .wmode_o (wmode),
    .pmode_o (pmode),
    .clr_o   (w_clr)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    assign periph_irq[i] = en[i] && (pmode[i] == SENSE_HIGH) && p_sync[i];
    // R2: a peripheral line never fires without its enable
    a_r2_periph_gated: assert property (@(posedge clk) disable iff (!rst_n)
      periph_irq[i] |-> en[i]);
  end

  for (genvar j = 0; j < NUM_WAKE; j++) begin : g_wake
    wk_wake_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_i    (w_sync[j]),
      .mode_i   (wmode[j]),
      .en_i     (en[SLOTS + j]),
      .clr_i    (w_clr[j]),
      .active_o (w_act[j])
    );
  end

  always_comb begin
    status = '0;
    status[NUM_PERIPH-1:0]          = periph_irq;
    status[SLOTS +: NUM_WAKE]       = w_act;
  end

  assign wake_irq = |w_act;
  assign wake_req = wake_irq | (|periph_irq);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_EN:    rd_data[2*SLOTS-1:0] = en;
      ADDR_STAT:  rd_data[2*SLOTS-1:0] = status;
      ADDR_WMODE: begin
        for (int j = 0; j < NUM_WAKE; j++)
          rd_data[MODE_W*j +: MODE_W] = wmode[j];
      end
      default: begin
        for (int i = 0; i < NUM_PERIPH; i++)
          rd_data[MODE_W*i +: MODE_W] = pmode[i];
      end
    endcase
  end

  // R8: the shared wake interrupt needs at least one wake enable
  a_r8_wake_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (|en[SLOTS +: NUM_WAKE]));
  // R9: a wake request is raised whenever the shared interrupt is
  a_r9_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_req);
endmodule

// File: tb/wake_sense_ctrl_tb.sv
module wake_sense_ctrl_tb;
  localparam int NP = 8;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] periph_in = '0;
  logic [NW-1:0] wake_in = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] periph_irq;
  logic          wake_irq;
  logic          wake_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_sense_ctrl #(.NUM_PERIPH(NP), .NUM_WAKE(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .periph_in(periph_in), .wake_in(wake_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .periph_irq(periph_irq), .wake_irq(wake_irq),
    .wake_req(wake_req)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] pnorm(logic [31:0] w);
    logic [31:0] r = '0;
    for (int i = 0; i < NP; i++)
      r[4*i +: 4] = (w[4*i +: 4] == 4'd0) ? 4'd0 : 4'd4;
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int codes [8] = '{0, 1, 2, 3, 4, 8, 5, 12};
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R11 reg reset", d, 32'h0);
    end
    check("R11 outputs reset", {22'd0, periph_irq, wake_irq, wake_req}, 32'h0);

    // R3: peripheral code normalisation
    wr(2'd3, 32'h0F30_9201);
    rd(2'd3, d);
    check("R3 pmode normalised", d, pnorm(32'h0F30_9201));
    wr(2'd3, 32'h4444_4444);
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, d);
    check("R1 enable readback", d, 32'h0000_FFFF);

    // R10: level latency on peripheral 0
    periph_in[0] = 1'b1;
    tick(1);
    check("R10 level not yet", {31'd0, periph_irq[0]}, 32'd0);
    tick(1);
    check("R10 level after two", {31'd0, periph_irq[0]}, 32'd1);
    periph_in[0] = 1'b0;
    tick(3);

    // R2 R9 R1: peripheral sweep, each line with enable on/off
    for (int i = 0; i < NP; i++) begin
      for (int e = 0; e < 2; e++) begin
        wr(2'd0, e ? (32'h1 << i) : 32'h0);
        periph_in = '0;
        periph_in[i] = 1'b1;
        tick(3);
        check("R2 periph line", {24'd0, periph_irq}, e ? (32'h1 << i) : 32'h0);
        check("R9 req from periph", {31'd0, wake_req}, e);
        rd(2'd1, d);
        check("R1 periph status bit", d, e ? (32'h1 << i) : 32'h0);
        periph_in = '0;
        tick(3);
      end
    end
    // R2: mode 0 disables an enabled line
    wr(2'd0, 32'h0000_00FF);
    wr(2'd3, 32'h4444_4404);
    periph_in = 8'h03;
    tick(3);
    check("R2 mode off masks", {24'd0, periph_irq}, 32'h01);
    periph_in = '0;
    wr(2'd3, 32'h4444_4444);

    // R10: edge latency on wake 0, rising
    wr(2'd0, 32'h0000_FF00);
    wr(2'd2, 32'h0000_0001);
    tick(3);
    wake_in[0] = 1'b1;
    tick(2);
    check("R10 edge not yet", {31'd0, wake_irq}, 32'd0);
    tick(1);
    check("R10 edge after three", {31'd0, wake_irq}, 32'd1);
    wake_in[0] = 1'b0;
    wr(2'd2, 32'h0);
    tick(3);

    // R4 R5 R6 R7 R8 R9: every lane through every code
    for (int j = 0; j < NW; j++) begin
      foreach (codes[k]) begin
        int m;
        bit lat, lvl, act;
        m = codes[k];
        lat = 0;
        wake_in = '0;
        wr(2'd2, 32'(m) << (4*j));
        tick(3);
        wr(2'd1, 32'h0000_FF00);
        lvl = (m == 8);
        act = lvl;
        check("R5 R6 idle low", {31'd0, wake_irq}, act);
        // rise
        wake_in[j] = 1'b1;
        tick(4);
        if (m == 1 || m == 3) lat = 1;
        lvl = (m == 4);
        act = (m >= 1 && m <= 3) ? lat : lvl;
        check("R4 R5 R6 after rise", {31'd0, wake_irq}, act);
        check("R9 req after rise", {31'd0, wake_req}, act);
        rd(2'd1, d);
        check("R1 R8 wake status", d, act ? (32'h100 << j) : 32'h0);
        // fall
        wake_in[j] = 1'b0;
        tick(4);
        if (m == 2 || m == 3) lat = 1;
        lvl = (m == 8);
        act = (m >= 1 && m <= 3) ? lat : lvl;
        check("R4 R5 R6 after fall", {31'd0, wake_irq}, act);
        // R7: zero write and low-byte write leave the latch
        wr(2'd1, 32'h0000_00FF);
        check("R7 zeros ignored", {31'd0, wake_irq}, act);
        wr(2'd1, 32'h100 << j);
        if (m >= 1 && m <= 3) lat = 0;
        act = (m >= 1 && m <= 3) ? lat : lvl;
        check("R7 w1c clears", {31'd0, wake_irq}, act);
        wr(2'd2, 32'h0);
      end
    end

    // R6: a code change drops a latched event
    wr(2'd2, 32'h0000_0003);
    tick(2);
    wake_in[0] = 1'b1;
    tick(4);
    check("R6 latched before change", {31'd0, wake_irq}, 32'd1);
    wr(2'd2, 32'h0000_0005);
    tick(1);
    check("R6 code change drops", {31'd0, wake_irq}, 32'd0);
    wr(2'd2, 32'h0000_0003);
    tick(2);
    check("R6 no revival", {31'd0, wake_irq}, 32'd0);
    wake_in = '0;
    tick(4);
    wr(2'd1, 32'h0000_FF00);

    // R12: edge while disabled is not latched
    wr(2'd2, 32'h0000_0001);
    wr(2'd0, 32'h0);
    wake_in[0] = 1'b1;
    tick(4);
    wr(2'd0, 32'h0000_0100);
    tick(3);
    check("R12 disabled edge dropped", {31'd0, wake_irq}, 32'd0);
    rd(2'd1, d);
    check("R12 status clear", d, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule